// File: doc/BRIEF.md
# Banked Port Control Register File

This block is the register storage behind a serial slave's byte-wide register bus. The bus offers an 8-bit address, a write strobe with write data, and a combinational read-data return. The block keeps a handful of global control registers. It also keeps one set of per-output-port registers for each of four transmitter ports. All four copies share one address window, so the host first programs a 2-bit copy select in a global register. Every later access to a per-port address then reaches only that copy.

Each byte applies its own access rules. Some bits are fully writable. Some are forced to a constant. Some are read-only status taken from synchronized inputs. A few registers mix writable and read-only fields in the same byte. The stored control fields drive output vectors, one slice per port, so the analog transmitter and receiver logic can use them directly. An active-low asynchronous reset returns every register to its defined value.

Top module: `regbank_top`

## Requirements
- R1: After reset, reads return 0x05 at 0x05, 0x00 at 0x06, 0x08 in bits 3:0 of 0x07, 0x01 at 0x08, 0x80 at 0x0A, 0x01 at 0x0E and 0x00 at 0x0F, for every port copy.
- R2: At 0x05, bits 5:1 are writable, bits 7:6 always read 0 and bit 0 always reads 1, whatever was written.
- R3: Addresses 0x06 and 0x0A are fully writable 8-bit registers that read back the last value written.
- R4: At 0x07, bits 7:4 read the synchronized status {link present, DE toggling, HDMI input, decryption active} from bit 7 down to bit 4, and writes do not change them. Bit 3 is the writable receiver power-up, bit 2 reads 0, and bits 1:0 are the writable port select.
- R5: With port select value n (00 = port 0, 01 = port 1, 10 = port 2, 11 = port 3), reads and writes of 0x08, 0x09, 0x0E and 0x0F reach copy n only, and the other copies keep their values.
- R6: 0x09 is read-only. Bit 1 is the synchronized receiver-sense input and bit 0 the synchronized hot-plug input of the selected port. Bits 7:2 read 0, and writes have no effect.
- R7: At 0x0E, bits 1:0 are writable, with bit 0 selecting HDMI (1) or DVI (0) signaling. Bits 7:2 read 0.
- R8: Reads of any address other than 0x05 to 0x0A, 0x0E and 0x0F return 0x00, and writes there change no register.
- R9: A change on a status input appears in read data after exactly two rising clock edges, and not after one.
- R10: Driving the reset input low restores all register values at once, without waiting for a clock edge.
- R11: The control outputs always equal the stored fields: each port's 0x08, 0x0E (2 bits) and 0x0F values in their own slices, port k at bits [8k+7:8k] (or [2k+1:2k] for the mode), plus the global fields.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe, sampled on the rising edge |
| addr | input | 8 | Register address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for addr, combinational |
| linkOn | input | 1 | Receiver clock present (asynchronous) |
| deOn | input | 1 | Receiver DE toggling (asynchronous) |
| hdmiIn | input | 1 | Receiver sees HDMI rather than DVI (asynchronous) |
| decryptOn | input | 1 | Receiver decryption active (asynchronous) |
| hotPlug | input | 4 | Hot-plug level per output port (asynchronous) |
| rxSense | input | 4 | Receiver sense per output port (asynchronous) |
| sampCtrl | output | 6 | Sampling parameter, bit 0 held at 1 |
| tmdsCtrl | output | 8 | Termination and equalisation control |
| auxCtrl | output | 8 | Global auxiliary control byte |
| rxPowerUp | output | 1 | Receiver power-up control |
| portSel | output | 2 | Current port copy select |
| txCtrl | output | 32 | Per-port control byte, port k at [8k+7:8k] |
| txMode | output | 8 | Per-port mode bits, port k at [2k+1:2k] |
| txHdcp | output | 32 | Per-port encryption control byte, port k at [8k+7:8k] |

## Verification
The bench goes after the banked window first. It writes distinct values into every copy and reads them all back. If the select were ignored or decoded wrongly, one copy would be overwritten and the values in the other slices would be wrong. Forced and read-only bits get writes of all ones. A design that stored them would read back 1s in bit 7 or 6 of 0x05, or a 0 in bit 0, or would change the status nibble of 0x07 or the value of 0x09. The bench toggles a hot-plug input one cycle at a time to show that the read value changes on the second edge. A design with one stage or three would change it a cycle early or late. Random traffic over the whole address space, unmapped addresses included, is compared against a bench model, so a decode that aliases an unmapped address onto a real register shows up as a corrupted read.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

  localparam int DEF_PORTS = 4;

  localparam logic [7:0] ADDR_SAMP  = 8'h05;
  localparam logic [7:0] ADDR_TMDS  = 8'h06;
  localparam logic [7:0] ADDR_GLOB  = 8'h07;
  localparam logic [7:0] ADDR_PCTRL = 8'h08;
  localparam logic [7:0] ADDR_PSTAT = 8'h09;
  localparam logic [7:0] ADDR_AUX   = 8'h0A;
  localparam logic [7:0] ADDR_PMODE = 8'h0E;
  localparam logic [7:0] ADDR_PHDCP = 8'h0F;

  localparam logic [4:0] RST_SAMP_HI = 5'b00010;  // bits 5:1 of 0x05
  localparam logic [7:0] RST_TMDS    = 8'h00;
  localparam logic       RST_RXPWR   = 1'b1;
  localparam logic [7:0] RST_AUX     = 8'h80;
  localparam logic [7:0] RST_PCTRL   = 8'h01;
  localparam logic [1:0] RST_PMODE   = 2'b01;
  localparam logic [7:0] RST_PHDCP   = 8'h00;

  typedef enum logic [3:0] {
    RD_NONE, RD_SAMP, RD_TMDS, RD_GLOB, RD_PCTRL,
    RD_PSTAT, RD_AUX, RD_PMODE, RD_PHDCP
  } rdSel_e;

  typedef struct packed {
    logic   wrSamp;
    logic   wrTmds;
    logic   wrGlob;
    logic   wrAux;
    logic   wrPortCtrl;
    logic   wrPortMode;
    logic   wrPortHdcp;
    rdSel_e rdSel;
  } strobes_t;

endpackage

// File: rtl/regbank_sync.sv
module regbank_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stageQ [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stageQ[0] <= '0;
    else       stageQ[0] <= asyncIn;
  end

  for (genvar s = 1; s < STAGES; s++) begin : gStage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stageQ[s] <= '0;
      else       stageQ[s] <= stageQ[s-1];
    end
  end

  assign syncOut = stageQ[STAGES-1];
endmodule

// File: rtl/regbank_ctrl.sv
module regbank_ctrl
  import regbank_pkg::*;
(
  input  logic       wrEn,
  input  logic [7:0] addr,
  output strobes_t   stb
);
  always_comb begin
    stb = '0;
    stb.rdSel = RD_NONE;
    unique case (addr)
      ADDR_SAMP:  begin stb.rdSel = RD_SAMP;  stb.wrSamp     = wrEn; end
      ADDR_TMDS:  begin stb.rdSel = RD_TMDS;  stb.wrTmds     = wrEn; end
      ADDR_GLOB:  begin stb.rdSel = RD_GLOB;  stb.wrGlob     = wrEn; end
      ADDR_PCTRL: begin stb.rdSel = RD_PCTRL; stb.wrPortCtrl = wrEn; end
      ADDR_PSTAT: begin stb.rdSel = RD_PSTAT; end
      ADDR_AUX:   begin stb.rdSel = RD_AUX;   stb.wrAux      = wrEn; end
      ADDR_PMODE: begin stb.rdSel = RD_PMODE; stb.wrPortMode = wrEn; end
      ADDR_PHDCP: begin stb.rdSel = RD_PHDCP; stb.wrPortHdcp = wrEn; end
      default:    begin stb.rdSel = RD_NONE; end
    endcase
  end
endmodule

// File: rtl/regbank_dp.sv
module regbank_dp
  import regbank_pkg::*;
#(
  parameter int NUM_PORTS = DEF_PORTS,
  localparam int SEL_W    = $clog2(NUM_PORTS)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  strobes_t               stb,
  input  logic [7:0]             wrData,
  input  logic [3:0]             rxStat,
  input  logic [NUM_PORTS-1:0]   hpSync,
  input  logic [NUM_PORTS-1:0]   rsSync,
  output logic [7:0]             rdData,
  output logic [5:0]             sampCtrl,
  output logic [7:0]             tmdsCtrl,
  output logic [7:0]             auxCtrl,
  output logic                   rxPowerUp,
  output logic [SEL_W-1:0]       portSel,
  output logic [NUM_PORTS*8-1:0] txCtrl,
  output logic [NUM_PORTS*2-1:0] txMode,
  output logic [NUM_PORTS*8-1:0] txHdcp
);
  logic [4:0]       sampHiQ;
  logic [7:0]       tmdsQ;
  logic [7:0]       auxQ;
  logic             rxPwrQ;
  logic [SEL_W-1:0] selQ;
  logic [7:0]       ctrlQ [NUM_PORTS];
  logic [1:0]       modeQ [NUM_PORTS];
  logic [7:0]       hdcpQ [NUM_PORTS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampHiQ <= RST_SAMP_HI;
      tmdsQ   <= RST_TMDS;
      auxQ    <= RST_AUX;
      rxPwrQ  <= RST_RXPWR;
      selQ    <= '0;
    end else begin
      if (stb.wrSamp) sampHiQ <= wrData[5:1];
      if (stb.wrTmds) tmdsQ   <= wrData;
      if (stb.wrAux)  auxQ    <= wrData;
      if (stb.wrGlob) begin
        rxPwrQ <= wrData[3];
        selQ   <= wrData[SEL_W-1:0];
      end
    end
  end

  for (genvar k = 0; k < NUM_PORTS; k++) begin : gPort
    logic hit;
    assign hit = (selQ == SEL_W'(k));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ctrlQ[k] <= RST_PCTRL;
        modeQ[k] <= RST_PMODE;
        hdcpQ[k] <= RST_PHDCP;
      end else if (hit) begin
        if (stb.wrPortCtrl) ctrlQ[k] <= wrData;
        if (stb.wrPortMode) modeQ[k] <= wrData[1:0];
        if (stb.wrPortHdcp) hdcpQ[k] <= wrData;
      end
    end

    assign txCtrl[k*8 +: 8] = ctrlQ[k];
    assign txMode[k*2 +: 2] = modeQ[k];
    assign txHdcp[k*8 +: 8] = hdcpQ[k];
  end

  always_comb begin
    rdData = 8'h00;
    unique case (stb.rdSel)
      RD_SAMP:  rdData = {2'b00, sampHiQ, 1'b1};
      RD_TMDS:  rdData = tmdsQ;
      RD_GLOB:  begin
        rdData[7:4]       = rxStat;
        rdData[3]         = rxPwrQ;
        rdData[SEL_W-1:0] = selQ;
      end
      RD_PCTRL: rdData = ctrlQ[selQ];
      RD_PSTAT: rdData = {6'b0, rsSync[selQ], hpSync[selQ]};
      RD_AUX:   rdData = auxQ;
      RD_PMODE: rdData = {6'b0, modeQ[selQ]};
      RD_PHDCP: rdData = hdcpQ[selQ];
      default:  rdData = 8'h00;
    endcase
  end

  assign sampCtrl  = {sampHiQ, 1'b1};
  assign tmdsCtrl  = tmdsQ;
  assign auxCtrl   = auxQ;
  assign rxPowerUp = rxPwrQ;
  assign portSel   = selQ;
endmodule

// File: rtl/regbank_top.sv
module regbank_top
  import regbank_pkg::*;
#(
  parameter int NUM_PORTS   = DEF_PORTS,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W      = $clog2(NUM_PORTS),
  localparam int STAT_W     = 4 + 2 * NUM_PORTS
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrEn,
  input  logic [7:0]             addr,
  input  logic [7:0]             wrData,
  output logic [7:0]             rdData,
  input  logic                   linkOn,
  input  logic                   deOn,
  input  logic                   hdmiIn,
  input  logic                   decryptOn,
  input  logic [NUM_PORTS-1:0]   hotPlug,
  input  logic [NUM_PORTS-1:0]   rxSense,
  output logic [5:0]             sampCtrl,
  output logic [7:0]             tmdsCtrl,
  output logic [7:0]             auxCtrl,
  output logic                   rxPowerUp,
  output logic [SEL_W-1:0]       portSel,
  output logic [NUM_PORTS*8-1:0] txCtrl,
  output logic [NUM_PORTS*2-1:0] txMode,
  output logic [NUM_PORTS*8-1:0] txHdcp
);
  strobes_t          stb;
  logic [STAT_W-1:0] statSync;

  regbank_sync #(.WIDTH(STAT_W), .STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN),
    .asyncIn({linkOn, deOn, hdmiIn, decryptOn, hotPlug, rxSense}),
    .syncOut(statSync)
  );

  regbank_ctrl uCtrl (.wrEn(wrEn), .addr(addr), .stb(stb));

  regbank_dp #(.NUM_PORTS(NUM_PORTS)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData),
    .rxStat(statSync[STAT_W-1 -: 4]),
    .hpSync(statSync[2*NUM_PORTS-1 -: NUM_PORTS]),
    .rsSync(statSync[NUM_PORTS-1:0]),
    .rdData(rdData), .sampCtrl(sampCtrl), .tmdsCtrl(tmdsCtrl),
    .auxCtrl(auxCtrl), .rxPowerUp(rxPowerUp), .portSel(portSel),
    .txCtrl(txCtrl), .txMode(txMode), .txHdcp(txHdcp)
  );
endmodule

// File: rtl/regbank_chk.sv
module regbank_chk #(
  parameter int NUM_PORTS = 4,
  localparam int SEL_W    = $clog2(NUM_PORTS)
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   wrEn,
  input logic [7:0]             addr,
  input logic [7:0]             wrData,
  input logic [7:0]             rdData,
  input logic                   linkOn,
  input logic                   deOn,
  input logic                   hdmiIn,
  input logic                   decryptOn,
  input logic [7:0]             tmdsCtrl,
  input logic [7:0]             auxCtrl,
  input logic [SEL_W-1:0]       portSel,
  input logic [NUM_PORTS*8-1:0] txHdcp
);
  logic [1:0] edgeCnt;
  logic       unmapped;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              edgeCnt <= '0;
    else if (edgeCnt != 2'd3) edgeCnt <= edgeCnt + 2'd1;
  end

  assign unmapped = !((addr >= 8'h05 && addr <= 8'h0A) || addr == 8'h0E || addr == 8'h0F);

  assert_forced_bits_R2: assert property (@(posedge clk) disable iff (!rstN)
    (addr == 8'h05) |-> (rdData[7:6] == 2'b00 && rdData[0]));

  assert_full_rw_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 8'h06) |=> (tmdsCtrl == $past(wrData)));

  assert_aux_rw_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 8'h0A) |=> (auxCtrl == $past(wrData)));

  assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    unmapped |-> (rdData == 8'h00));

  assert_sync_delay_R9: assert property (@(posedge clk) disable iff (!rstN)
    (edgeCnt >= 2'd2 && addr == 8'h07) |->
      (rdData[7:4] == $past({linkOn, deOn, hdmiIn, decryptOn}, 2)));

  for (genvar k = 0; k < NUM_PORTS; k++) begin : gChk
    assert_bank_write_R5: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && addr == 8'h0F && portSel == SEL_W'(k)) |=> (txHdcp[k*8 +: 8] == $past(wrData)));
    assert_bank_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && addr == 8'h0F && portSel != SEL_W'(k)) |=> $stable(txHdcp[k*8 +: 8]));
  end
endmodule

bind regbank_top regbank_chk #(.NUM_PORTS(NUM_PORTS)) uChk (.*);

// File: tb/sim_regbank_top.sv
module sim_regbank_top;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic linkOn = 1'b0, deOn = 1'b0, hdmiIn = 1'b0, decryptOn = 1'b0;
  logic [NP-1:0] hotPlug = '0, rxSense = '0;
  logic [5:0] sampCtrl;
  logic [7:0] tmdsCtrl, auxCtrl;
  logic rxPowerUp;
  logic [1:0] portSel;
  logic [NP*8-1:0] txCtrl, txHdcp;
  logic [NP*2-1:0] txMode;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  logic [4:0] mSamp;
  logic [7:0] mTmds, mAux;
  logic mPwr;
  logic [1:0] mSel;
  logic [7:0] mCtrl [NP];
  logic [1:0] mMode [NP];
  logic [7:0] mHdcp [NP];

  regbank_top u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic modelReset();
    mSamp = 5'b00010; mTmds = 8'h00; mAux = 8'h80; mPwr = 1'b1; mSel = 2'd0;
    for (int k = 0; k < NP; k++) begin
      mCtrl[k] = 8'h01; mMode[k] = 2'b01; mHdcp[k] = 8'h00;
    end
  endtask

  task automatic modelWrite(logic [7:0] a, logic [7:0] d);
    case (a)
      8'h05: mSamp = d[5:1];
      8'h06: mTmds = d;
      8'h07: begin mPwr = d[3]; mSel = d[1:0]; end
      8'h08: mCtrl[mSel] = d;
      8'h0A: mAux = d;
      8'h0E: mMode[mSel] = d[1:0];
      8'h0F: mHdcp[mSel] = d;
      default: ;
    endcase
  endtask

  function automatic logic [7:0] expRead(logic [7:0] a);
    case (a)
      8'h05: return {2'b00, mSamp, 1'b1};
      8'h06: return mTmds;
      8'h07: return {linkOn, deOn, hdmiIn, decryptOn, mPwr, 1'b0, mSel};
      8'h08: return mCtrl[mSel];
      8'h09: return {6'b0, rxSense[mSel], hotPlug[mSel]};
      8'h0A: return mAux;
      8'h0E: return {6'b0, mMode[mSel]};
      8'h0F: return mHdcp[mSel];
      default: return 8'h00;
    endcase
  endfunction

  task automatic doWrite(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    modelWrite(a, d);
  endtask

  task automatic doRead(logic [7:0] a, output logic [7:0] v);
    addr = a;
    #1;
    v = rdData;
  endtask

  task automatic readCheck(string tag, logic [7:0] a);
    logic [7:0] v;
    doRead(a, v);
    check(tag, {24'h0, v}, {24'h0, expRead(a)});
  endtask

  task automatic checkOutputs(string tag);
    logic [NP*8-1:0] eC, eH;
    logic [NP*2-1:0] eM;
    for (int k = 0; k < NP; k++) begin
      eC[k*8 +: 8] = mCtrl[k]; eH[k*8 +: 8] = mHdcp[k]; eM[k*2 +: 2] = mMode[k];
    end
    check({tag, " txCtrl"}, txCtrl, eC);
    check({tag, " txHdcp"}, txHdcp, eH);
    check({tag, " txMode"}, {24'h0, txMode}, {24'h0, eM});
    check({tag, " globals"},
          {2'b0, sampCtrl, tmdsCtrl, auxCtrl, rxPowerUp, 5'b0, portSel},
          {2'b0, mSamp, 1'b1, mTmds, mAux, mPwr, 5'b0, mSel});
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, a, d;
    void'($urandom(32'd20240611));
    modelReset();
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    settle();

    // R1: reset values, each copy
    foreach (mCtrl[k]) begin end
    readCheck("R1 samp", 8'h05);
    readCheck("R1 tmds", 8'h06);
    readCheck("R1 glob", 8'h07);
    readCheck("R1 aux", 8'h0A);
    for (int k = 0; k < NP; k++) begin
      doWrite(8'h07, 8'h08 | 8'(k));
      readCheck("R1 pctrl", 8'h08);
      readCheck("R1 pmode", 8'h0E);
      readCheck("R1 phdcp", 8'h0F);
    end
    doWrite(8'h07, 8'h08);
    checkOutputs("R11 after reset");

    // R2: forced and constant bits at 0x05
    doWrite(8'h05, 8'hFE);
    readCheck("R2 write FE", 8'h05);
    check("R2 value", {24'h0, rdData}, 32'h3F);
    doWrite(8'h05, 8'h00);
    readCheck("R2 write 00", 8'h05);

    // R3: full-width registers
    doWrite(8'h06, 8'hA5); readCheck("R3 tmds", 8'h06);
    doWrite(8'h0A, 8'h3C); readCheck("R3 aux", 8'h0A);

    // R4: status nibble read-only, writable fields
    {linkOn, deOn, hdmiIn, decryptOn} = 4'b1010;
    settle();
    doWrite(8'h07, 8'h55);
    doRead(8'h07, v);
    check("R4 glob mixed", {24'h0, v}, 32'hA1);
    doWrite(8'h07, 8'hF6);
    readCheck("R4 status ignores write", 8'h07);

    // R5/R11: distinct values in every copy
    for (int k = 0; k < NP; k++) begin
      doWrite(8'h07, 8'(k));
      doWrite(8'h08, 8'h10 + 8'(k));
      doWrite(8'h0E, 8'(k));
      doWrite(8'h0F, 8'h20 + 8'(k));
    end
    for (int k = 0; k < NP; k++) begin
      doWrite(8'h07, 8'(k));
      readCheck("R5 pctrl", 8'h08);
      readCheck("R5 pmode", 8'h0E);
      readCheck("R5 phdcp", 8'h0F);
    end
    checkOutputs("R11 banked");

    // R6: per-port status, read-only
    hotPlug = 4'b0101; rxSense = 4'b0011;
    settle();
    for (int k = 0; k < NP; k++) begin
      doWrite(8'h07, 8'(k));
      readCheck("R6 pstat", 8'h09);
      doWrite(8'h09, 8'hFF);
      readCheck("R6 pstat after write", 8'h09);
    end

    // R7: mode register width
    doWrite(8'h0E, 8'hFF);
    doRead(8'h0E, v);
    check("R7 pmode FF", {24'h0, v}, 32'h03);
    doWrite(8'h0E, 8'h00);
    readCheck("R7 pmode DVI", 8'h0E);

    // R8: unmapped addresses
    doWrite(8'h00, 8'hFF);
    doWrite(8'h10, 8'hFF);
    doWrite(8'hFF, 8'hFF);
    readCheck("R8 read 00", 8'h00);
    readCheck("R8 read 0B", 8'h0B);
    readCheck("R8 read FF", 8'hFF);
    readCheck("R8 tmds kept", 8'h06);
    checkOutputs("R8 outputs kept");

    // R9: two-edge synchronizer latency on hot-plug of port 0
    doWrite(8'h07, 8'h00);
    @(negedge clk);
    hotPlug[0] = 1'b0;
    settle();
    hotPlug[0] = 1'b1;
    @(negedge clk);
    doRead(8'h09, v);
    check("R9 after one edge", {31'h0, v[0]}, 32'h0);
    @(negedge clk);
    doRead(8'h09, v);
    check("R9 after two edges", {31'h0, v[0]}, 32'h1);

    // Random traffic
    for (int i = 0; i < 800; i++) begin
      case ($urandom % 4)
        0: a = 8'($urandom);
        1: a = 8'h07;
        default: a = 8'h05 + 8'($urandom % 11);
      endcase
      d = 8'($urandom);
      if (a == 8'h07) d[3] = 1'($urandom);
      doWrite(a, d);
      readCheck("R5 random readback", a);
      if (i % 40 == 0) checkOutputs("R11 random");
    end

    // R10: asynchronous reset without a clock edge
    @(negedge clk);
    #1;
    rstN = 1'b0;
    #1;
    modelReset();
    doRead(8'h06, v);
    check("R10 tmds async", {24'h0, v}, 32'h00);
    doRead(8'h0A, v);
    check("R10 aux async", {24'h0, v}, 32'h80);
    checkOutputs("R10 outputs");
    @(negedge clk);
    rstN = 1'b1;
    settle();
    readCheck("R10 glob after release", 8'h07);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule